// File: doc/BRIEF.md
# Attribute Register Bank with Shared Index/Data Port

This block holds the attribute-stage configuration of a character/graphics display engine: a set of palette-index entries followed by five control registers (mode, border colour, plane mask, fine horizontal shift and colour-select). Software reaches all of them through one shared write port. A toggle inside the block decides whether a write to that port names a register (index phase) or loads the named register (data phase). Software puts the toggle into a known state by reading a separate status port. The read has that side effect.

The byte written in the index phase carries a lock bit next to the register number. While the lock bit is set, the picture is enabled and the palette entries are shielded from writes. The control registers can still be written. The selected register is read back through its own data port, and reading it does not move the toggle. Every register value is driven out in parallel for the pixel pipeline.

Top module: `attr_ctl`

## Requirements
- R1: After reset the toggle is in the index phase, `video_en` is 0, every register output is 0, and reads of the status and data ports return 0.
- R2: A write to the shared port (`addr`=0) in the index phase stores bits 4:0 as the selected register and bit 5 as the lock bit, and moves the toggle to the data phase. A read of `addr`=0 returns {2'b00, lock, index}.
- R3: A write to the shared port in the data phase loads the selected register and returns the toggle to the index phase, so the following write is an index again.
- R4: A read strobe at the status port (`addr`=2) forces the toggle to the index phase, including after an index write whose data write has not yet arrived.
- R5: `video_en` equals the lock bit (index bit 5) of the last index write. While it is 1, data writes to palette entries are dropped and those entries keep their values.
- R6: While the lock bit is 0, a data write to entry n (0 to NUM_PAL-1) appears on `pal_flat[n*DATA_W +: DATA_W]`, and a read of the data port returns it.
- R7: Writes to the control registers succeed whatever the lock bit. Index 0x10 is mode (8 bits), 0x11 is border colour (8 bits), 0x12 is plane mask (bits 3:0 kept), 0x13 is fine shift (bits 2:0 kept) and 0x14 is colour-select (8 bits). The unused upper bits read back as 0.
- R8: Indices 0x15 to 0x1F read as 0 through the data port, and a data write to any of them changes no output.
- R9: A read of the data port (`addr`=1) leaves the toggle where it was.
- R10: A read of the status port returns bit 0 = `video_en` and bit 1 = toggle (1 means the next shared write is data), with all other bits 0. The value shown is the state before the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Port select: 0 shared index/data, 1 data readback, 2 status |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe (side effect only at the status port) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the port selected by `addr` (combinational) |
| video_en | output | 1 | Picture enable / palette lock |
| pal_flat | output | NUM_PAL*DATA_W | All palette entries, entry n at bits n*DATA_W |
| mode_reg | output | DATA_W | Mode register |
| border_reg | output | DATA_W | Border colour register |
| plane_mask | output | PLANES | Plane enable mask |
| fine_shift | output | SHIFT_W | Fine horizontal shift in pixels |
| csel_reg | output | DATA_W | Colour-select register |

## Verification
The bench builds the block with its default parameters: 8-bit data, 16 palette entries, a 4-bit plane mask and a 3-bit shift. These values give a 5-bit index, so the unused indices 0x15 to 0x1F can be reached from the bus. Their reads and dropped writes can then be tested next to the last real register. With the lock bit at bit 5, just above the index, one written byte can hold both a real index and a set lock. That allows locked writes to the palette and to the control registers to be compared.

// File: rtl/attr_pkg.sv
package attr_pkg;

  typedef enum logic [1:0] {
    PORT_SHARED  = 2'd0,
    PORT_DATA_RD = 2'd1,
    PORT_STATUS  = 2'd2,
    PORT_SPARE   = 2'd3
  } port_e;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

endpackage

// File: rtl/attr_ctl_rst_sync.sv
module attr_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/attr_ctl_seq.sv
module attr_ctl_seq #(
  parameter int IDX_W   = 5,
  parameter int ACC_BIT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_shared,
  input  logic               rd_status,
  input  logic [ACC_BIT:0]   wbits,
  output logic               phase,
  output logic [IDX_W-1:0]   idx,
  output logic               lock,
  output logic               data_we
);
  import attr_pkg::*;

  phase_e            phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              lock_q, lock_d;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    lock_d  = lock_q;
    if (rd_status) begin
      phase_d = PH_INDEX;
    end else if (wr_shared) begin
      if (phase_q == PH_INDEX) begin
        idx_d   = wbits[IDX_W-1:0];
        lock_d  = wbits[ACC_BIT];
        phase_d = PH_DATA;
      end else begin
        phase_d = PH_INDEX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INDEX;
      idx_q   <= '0;
      lock_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      lock_q  <= lock_d;
    end
  end

  assign phase   = (phase_q == PH_DATA);
  assign idx     = idx_q;
  assign lock    = lock_q;
  assign data_we = wr_shared && !rd_status && (phase_q == PH_DATA);

endmodule

// File: rtl/attr_ctl_regs.sv
module attr_ctl_regs #(
  parameter int DATA_W  = 8,
  parameter int NUM_PAL = 16,
  parameter int PLANES  = 4,
  parameter int SHIFT_W = 3,
  parameter int IDX_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic                      lock,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_PAL*DATA_W-1:0] pal_flat,
  output logic [DATA_W-1:0]         mode_q,
  output logic [DATA_W-1:0]         border_q,
  output logic [PLANES-1:0]         plane_q,
  output logic [SHIFT_W-1:0]        shift_q,
  output logic [DATA_W-1:0]         csel_q
);

  localparam logic [IDX_W-1:0] IDX_MODE   = IDX_W'(NUM_PAL);
  localparam logic [IDX_W-1:0] IDX_BORDER = IDX_W'(NUM_PAL + 1);
  localparam logic [IDX_W-1:0] IDX_PLANE  = IDX_W'(NUM_PAL + 2);
  localparam logic [IDX_W-1:0] IDX_SHIFT  = IDX_W'(NUM_PAL + 3);
  localparam logic [IDX_W-1:0] IDX_CSEL   = IDX_W'(NUM_PAL + 4);

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    logic              en;
    logic [DATA_W-1:0] ent_q;
    assign en = we && !lock && (widx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= '0;
      else if (en) ent_q <= wdata;
    end
    assign pal_flat[g*DATA_W +: DATA_W] = ent_q;
  end

  logic mode_en, border_en, plane_en, shift_en, csel_en;

  always_comb begin
    mode_en   = we && (widx == IDX_MODE);
    border_en = we && (widx == IDX_BORDER);
    plane_en  = we && (widx == IDX_PLANE);
    shift_en  = we && (widx == IDX_SHIFT);
    csel_en   = we && (widx == IDX_CSEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      border_q <= '0;
      plane_q  <= '0;
      shift_q  <= '0;
      csel_q   <= '0;
    end else begin
      if (mode_en)   mode_q   <= wdata;
      if (border_en) border_q <= wdata;
      if (plane_en)  plane_q  <= wdata[PLANES-1:0];
      if (shift_en)  shift_q  <= wdata[SHIFT_W-1:0];
      if (csel_en)   csel_q   <= wdata;
    end
  end

endmodule

// File: rtl/attr_ctl_rdmux.sv
module attr_ctl_rdmux #(
  parameter int DATA_W  = 8,
  parameter int NUM_PAL = 16,
  parameter int PLANES  = 4,
  parameter int SHIFT_W = 3,
  parameter int IDX_W   = 5,
  parameter int ACC_BIT = 5
) (
  input  logic [1:0]                addr,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      lock,
  input  logic                      phase,
  input  logic [NUM_PAL*DATA_W-1:0] pal_flat,
  input  logic [DATA_W-1:0]         mode_q,
  input  logic [DATA_W-1:0]         border_q,
  input  logic [PLANES-1:0]         plane_q,
  input  logic [SHIFT_W-1:0]        shift_q,
  input  logic [DATA_W-1:0]         csel_q,
  output logic [DATA_W-1:0]         rdata
);
  import attr_pkg::*;

  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] idx_val;
  logic [DATA_W-1:0] stat_val;

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_PAL; i++) begin
      if (idx == IDX_W'(i)) sel_val = pal_flat[i*DATA_W +: DATA_W];
    end
    if (idx == IDX_W'(NUM_PAL))     sel_val = mode_q;
    if (idx == IDX_W'(NUM_PAL + 1)) sel_val = border_q;
    if (idx == IDX_W'(NUM_PAL + 2)) sel_val = DATA_W'(plane_q);
    if (idx == IDX_W'(NUM_PAL + 3)) sel_val = DATA_W'(shift_q);
    if (idx == IDX_W'(NUM_PAL + 4)) sel_val = csel_q;
  end

  always_comb begin
    idx_val          = '0;
    idx_val[IDX_W-1:0] = idx;
    idx_val[ACC_BIT] = lock;
    stat_val         = '0;
    stat_val[0]      = lock;
    stat_val[1]      = phase;
  end

  always_comb begin
    case (port_e'(addr))
      PORT_SHARED:  rdata = idx_val;
      PORT_DATA_RD: rdata = sel_val;
      PORT_STATUS:  rdata = stat_val;
      default:      rdata = '0;
    endcase
  end

endmodule

// File: rtl/attr_ctl.sv
module attr_ctl #(
  parameter int DATA_W  = 8,
  parameter int NUM_PAL = 16,
  parameter int PLANES  = 4,
  parameter int SHIFT_W = 3,
  parameter int ACC_BIT = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                addr,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      video_en,
  output logic [NUM_PAL*DATA_W-1:0] pal_flat,
  output logic [DATA_W-1:0]         mode_reg,
  output logic [DATA_W-1:0]         border_reg,
  output logic [PLANES-1:0]         plane_mask,
  output logic [SHIFT_W-1:0]        fine_shift,
  output logic [DATA_W-1:0]         csel_reg
);
  import attr_pkg::*;

  localparam int IDX_W = $clog2(NUM_PAL + 5);

  logic             rst_sync_n;
  logic             wr_shared, rd_status;
  logic             phase_q, lock_q, data_we;
  logic [IDX_W-1:0] idx_q;

  assign wr_shared = wr && (port_e'(addr) == PORT_SHARED);
  assign rd_status = rd && (port_e'(addr) == PORT_STATUS);

  attr_ctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  attr_ctl_seq #(.IDX_W(IDX_W), .ACC_BIT(ACC_BIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_shared (wr_shared),
    .rd_status (rd_status),
    .wbits     (wdata[ACC_BIT:0]),
    .phase     (phase_q),
    .idx       (idx_q),
    .lock      (lock_q),
    .data_we   (data_we)
  );

  attr_ctl_regs #(
    .DATA_W(DATA_W), .NUM_PAL(NUM_PAL), .PLANES(PLANES),
    .SHIFT_W(SHIFT_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (data_we),
    .widx     (idx_q),
    .lock     (lock_q),
    .wdata    (wdata),
    .pal_flat (pal_flat),
    .mode_q   (mode_reg),
    .border_q (border_reg),
    .plane_q  (plane_mask),
    .shift_q  (fine_shift),
    .csel_q   (csel_reg)
  );

  attr_ctl_rdmux #(
    .DATA_W(DATA_W), .NUM_PAL(NUM_PAL), .PLANES(PLANES),
    .SHIFT_W(SHIFT_W), .IDX_W(IDX_W), .ACC_BIT(ACC_BIT)
  ) u_rd (
    .addr     (addr),
    .idx      (idx_q),
    .lock     (lock_q),
    .phase    (phase_q),
    .pal_flat (pal_flat),
    .mode_q   (mode_reg),
    .border_q (border_reg),
    .plane_q  (plane_mask),
    .shift_q  (fine_shift),
    .csel_q   (csel_reg),
    .rdata    (rdata)
  );

  assign video_en = lock_q;

endmodule

// File: rtl/attr_ctl_chk.sv
module attr_ctl_chk #(
  parameter int DATA_W  = 8,
  parameter int NUM_PAL = 16,
  parameter int IDX_W   = 5,
  parameter int ACC_BIT = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                addr,
  input logic                      wr,
  input logic                      rd,
  input logic [DATA_W-1:0]         wdata,
  input logic                      phase,
  input logic [IDX_W-1:0]          idx,
  input logic                      video_en,
  input logic [NUM_PAL*DATA_W-1:0] pal_flat,
  input logic [DATA_W-1:0]         mode_reg,
  input logic [DATA_W-1:0]         border_reg,
  input logic [DATA_W-1:0]         csel_reg
);

  logic sh_wr, st_rd;
  assign sh_wr = wr && (addr == 2'd0);
  assign st_rd = rd && (addr == 2'd2);

  AST_INDEX_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && !phase) |=> phase);  // R2
  AST_DATA_TO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && phase) |=> !phase);  // R3
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> !phase);  // R4
  AST_LOCK_FOLLOWS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && !phase) |=> (video_en == $past(wdata[ACC_BIT])));  // R5
  AST_LOCKED_PAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && phase && video_en && (int'(idx) < NUM_PAL)) |=> $stable(pal_flat));  // R5
  AST_MODE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && phase && (int'(idx) == NUM_PAL)) |=> (mode_reg == $past(wdata)));  // R7
  AST_SPARE_IDX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_wr && phase && (int'(idx) > NUM_PAL + 4))
      |=> ($stable(pal_flat) && $stable(mode_reg) && $stable(border_reg) && $stable(csel_reg)));  // R8
  AST_DATA_RD_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == 2'd1) |=> $stable(phase));  // R9

endmodule

bind attr_ctl attr_ctl_chk #(
  .DATA_W(DATA_W), .NUM_PAL(NUM_PAL), .IDX_W(IDX_W), .ACC_BIT(ACC_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr       (addr),
  .wr         (wr),
  .rd         (rd),
  .wdata      (wdata),
  .phase      (phase_q),
  .idx        (idx_q),
  .video_en   (video_en),
  .pal_flat   (pal_flat),
  .mode_reg   (mode_reg),
  .border_reg (border_reg),
  .csel_reg   (csel_reg)
);

// File: tb/attr_ctl_test.sv
module attr_ctl_test;

  localparam int CLK_P   = 10;
  localparam int DATA_W  = 8;
  localparam int NUM_PAL = 16;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic [1:0]                addr;
  logic                      wr, rd;
  logic [DATA_W-1:0]         wdata;
  logic [DATA_W-1:0]         rdata;
  logic                      video_en;
  logic [NUM_PAL*DATA_W-1:0] pal_flat;
  logic [DATA_W-1:0]         mode_reg, border_reg, csel_reg;
  logic [3:0]                plane_mask;
  logic [2:0]                fine_shift;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  attr_ctl uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .video_en(video_en), .pal_flat(pal_flat),
    .mode_reg(mode_reg), .border_reg(border_reg), .plane_mask(plane_mask),
    .fine_shift(fine_shift), .csel_reg(csel_reg)
  );

  typedef struct packed {
    logic       is_rd;
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd1},  // R1 status after reset
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd1},  // R1 entry 0 after reset
    '{1'b0, 2'd0, 8'h03, 8'h00, 4'd6},  // index 3, unlocked
    '{1'b0, 2'd0, 8'h2A, 8'h00, 4'd6},  // data into entry 3
    '{1'b1, 2'd1, 8'h00, 8'h2A, 4'd6},  // R6 readback
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd3},  // R3 back to index phase
    '{1'b0, 2'd0, 8'h10, 8'h00, 4'd2},  // index mode
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd9},  // R9 data read, no phase change
    '{1'b1, 2'd2, 8'h00, 8'h02, 4'd9},  // R9 / R10 still data phase
    '{1'b0, 2'd0, 8'h33, 8'h00, 4'd5},  // index 0x13, lock set
    '{1'b1, 2'd0, 8'h00, 8'h33, 4'd2},  // R2 index readback
    '{1'b0, 2'd0, 8'hFF, 8'h00, 4'd7},  // shift <= 7 while locked
    '{1'b1, 2'd1, 8'h00, 8'h07, 4'd7},  // R7 shift masked to 3 bits
    '{1'b0, 2'd0, 8'h25, 8'h00, 4'd5},  // index 5, locked
    '{1'b0, 2'd0, 8'h11, 8'h00, 4'd5},  // dropped palette write
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd5},  // R5 entry 5 unchanged
    '{1'b1, 2'd2, 8'h00, 8'h01, 4'd10}, // R10 video on, index phase
    '{1'b0, 2'd0, 8'h12, 8'h00, 4'd4},  // index plane, unlocked
    '{1'b1, 2'd2, 8'h00, 8'h02, 4'd4},  // R4 clears mid-sequence
    '{1'b0, 2'd0, 8'h14, 8'h00, 4'd4},  // taken as index 0x14
    '{1'b0, 2'd0, 8'h9C, 8'h00, 4'd7},  // colour select
    '{1'b1, 2'd1, 8'h00, 8'h9C, 4'd7},  // R7 colour select readback
    '{1'b0, 2'd0, 8'h18, 8'h00, 4'd8},  // spare index
    '{1'b0, 2'd0, 8'h55, 8'h00, 4'd8},  // dropped
    '{1'b1, 2'd1, 8'h00, 8'h00, 4'd8},  // R8 reads zero
    '{1'b1, 2'd0, 8'h00, 8'h18, 4'd2},  // R2 index readback
    '{1'b1, 2'd2, 8'h00, 8'h00, 4'd3}   // R3 phase back to index
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [NUM_PAL*DATA_W-1:0] pal_snap;
    logic [7:0] m_snap, b_snap, c_snap;
    logic [3:0] p_snap;
    logic [2:0] s_snap;
    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1 outputs under reset
    check("R1 video_en", video_en, 1'b0);
    check("R1 palette", pal_flat, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_rd) begin
        rd_port(VEC[i].a, v);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
      end else begin
        wr_port(VEC[i].a, VEC[i].d);
      end
    end

    // R6 parallel outputs
    check("R6 entry3 output", pal_flat[3*8 +: 8], 8'h2A);
    check("R5 entry5 output", pal_flat[5*8 +: 8], 8'h00);
    check("R7 shift output", fine_shift, 3'd7);
    check("R7 csel output", csel_reg, 8'h9C);

    // R7 plane mask and border while locked
    rd_port(2'd2, v);
    wr_port(2'd0, 8'h32);
    wr_port(2'd0, 8'hFF);
    check("R7 plane output", plane_mask, 4'hF);
    rd_port(2'd1, v);
    check("R7 plane readback", v, 8'h0F);
    check("R5 video_en on", video_en, 1'b1);
    wr_port(2'd0, 8'h31);
    wr_port(2'd0, 8'h3C);
    check("R7 border output", border_reg, 8'h3C);
    wr_port(2'd0, 8'h30);
    wr_port(2'd0, 8'hA5);
    check("R7 mode output", mode_reg, 8'hA5);

    // R8 top spare index changes nothing
    pal_snap = pal_flat; m_snap = mode_reg; b_snap = border_reg;
    c_snap = csel_reg; p_snap = plane_mask; s_snap = fine_shift;
    wr_port(2'd0, 8'h1F);
    wr_port(2'd0, 8'hAA);
    check("R8 palette", pal_flat, pal_snap);
    check("R8 regs", {mode_reg, border_reg, csel_reg, plane_mask, fine_shift},
          {m_snap, b_snap, c_snap, p_snap, s_snap});
    rd_port(2'd1, v);
    check("R8 readback", v, 8'h00);

    // R6 last palette entry
    wr_port(2'd0, 8'h0F);
    wr_port(2'd0, 8'h77);
    check("R6 entry15 output", pal_flat[15*8 +: 8], 8'h77);
    check("R5 video off", video_en, 1'b0);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 regs after reset", {mode_reg, border_reg, csel_reg, plane_mask, fine_shift}, '0);
    check("R1 palette after reset", pal_flat, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_port(2'd2, v);
    check("R1 status after reset", v, 8'h00);

    finish_run();
  end

endmodule